// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register that converts a parallel word into a serial bit stream inside one system-clock domain. Its control pins behave like a stand-alone converter part: an active-low load input copies the parallel word into every stage, and a slow shift clock together with an active-low clock enable moves the word one place per shift event, with a serial input filling the first stage. Both a true and an inverted copy of the last stage are driven out.

The shift clock and the enable are ordinary signals sampled by the system clock. Their OR forms one gated clock, and a shift event is a rising edge of that gated clock seen in the sampled history. The load is level-sensitive and wins over everything else. A word is normally loaded and then shifted out most significant bit first. After eight shifts the serial input stream has taken its place.

Top module: `plso_shift8`

## Requirements
- R1: A synchronous active-high reset clears all stages to zero, so `sout_o` is 0 and `sout_n_o` is 1. No shift event is taken because the gated clock was already high during reset.
- R2: While `ld_n_i` is 0, all stages take `pin_i` at each system clock edge, whatever `sclk_i`, `sen_n_i` and `sdin_i` do. `sout_o` equals `pin_i[7]` one system clock later.
- R3: The load is a level. While `ld_n_i` stays 0, a change on `pin_i[7]` alone appears at `sout_o` one system clock later, with no shift clock needed.
- R4: With `ld_n_i` at 1, a rising edge of the gated clock `sclk_i | sen_n_i` shifts the register by one place. Stage n moves to stage n+1 and the serial bit enters stage 0. The outputs show the result two system clocks after the rise.
- R5: With `sen_n_i` at 1, toggling `sclk_i` has no effect and all stages hold.
- R6: `sout_n_o` is always the inverse of `sout_o`, and `sout_o` shows the last stage.
- R7: A rise of `sen_n_i` while `sclk_i` is 0 counts as a shift event. A fall of `sen_n_i` while `sclk_i` is 1 causes none.
- R8: The bit shifted in is the value `sdin_i` held in the cycle before the gated clock rose. A change of `sdin_i` in the same cycle as the rise is not taken.
- R9: After `ld_n_i` returns to 1, no shift happens until a fresh rise of the gated clock occurs, even if the gated clock rose while the load was active.
- R10: A loaded word leaves `sout_o` most significant bit first over eight shift events. The next eight shift events deliver the serial input bits in the order they were shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n_i | input | 1 | Parallel load, active low, level-sensitive |
| sclk_i | input | 1 | Shift clock, sampled |
| sen_n_i | input | 1 | Shift clock enable, active low |
| sdin_i | input | 1 | Serial data into stage 0 |
| pin_i | input | 8 | Parallel word, bit 7 goes to the last stage |
| sout_o | output | 1 | Last stage |
| sout_n_o | output | 1 | Inverse of the last stage |

## Verification
A load shows at the outputs one system clock after `ld_n_i` is seen low. A shift shows two system clocks after the gated clock rises, because one sample register and one history register lie in front of the edge detector. The bench changes every input on a falling system-clock edge and reads the outputs on a later falling edge, after exactly the number of rising edges each path needs. It sweeps all 256 load words through fifteen shifts each. The expected serial bit at every step comes from the word and the shift index.

// File: rtl/plso_pkg.sv
package plso_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // sampled history of the gated shift clock and the serial input
    typedef struct packed {
        logic g;         // gated clock, latest sample
        logic g_prev;    // gated clock, one sample older (forced high during load)
        logic ser;       // serial input, latest sample
        logic ser_prev;  // serial input, aligned with g_prev
    } samp_t;

    localparam samp_t SAMP_RST = '{g: 1'b1, g_prev: 1'b1, ser: 1'b0, ser_prev: 1'b0};

endpackage

// File: rtl/plso_sampler.sv
module plso_sampler
    import plso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_n_i,
    input  logic sclk_i,
    input  logic sen_n_i,
    input  logic sdin_i,
    output logic shift_o,
    output logic sbit_o
);

    samp_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.g        = sclk_i | sen_n_i;
        s_d.ser      = sdin_i;
        s_d.ser_prev = s_q.ser;
        // while loading, history is held high so release shows no edge
        s_d.g_prev   = ld_n_i ? s_q.g : 1'b1;
        if (rst) begin
            s_d = SAMP_RST;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign shift_o = ld_n_i & s_q.g & ~s_q.g_prev;
    assign sbit_o  = s_q.ser_prev;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        shift_o |=> !shift_o); // R4

    AST_NO_SHIFT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_n_i) |-> !shift_o); // R9

    AST_NO_SHIFT_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !shift_o); // R1

endmodule

// File: rtl/plso_stages.sv
module plso_stages #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n_i,
    input  logic             shift_i,
    input  logic             sbit_i,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] stages_o
);

    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] stages_d, stages_q;
    logic [WIDTH-1:0] shifted;

    for (genvar i = 0; i < WIDTH; i++) begin : g_link
        if (i == 0) begin : g_head
            assign shifted[i] = sbit_i;
        end else begin : g_body
            assign shifted[i] = stages_q[i-1];
        end
    end

    always_comb begin
        stages_d = stages_q;
        if (rst) begin
            stages_d = '0;
        end else if (!ld_n_i) begin
            stages_d = pin_i;
        end else if (shift_i) begin
            stages_d = shifted;
        end
    end

    always_ff @(posedge clk) begin
        stages_q <= stages_d;
    end

    assign stages_o = stages_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> stages_q == '0); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        !ld_n_i |=> stages_q == $past(pin_i)); // R2

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (ld_n_i && shift_i) |=> stages_q[LAST:1] == $past(stages_q[LAST-1:0])); // R4

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (ld_n_i && shift_i) |=> stages_q[0] == $past(sbit_i)); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_n_i && !shift_i) |=> $stable(stages_q)); // R5

endmodule

// File: rtl/plso_shift8.sv
module plso_shift8
    import plso_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n_i,
    input  logic             sclk_i,
    input  logic             sen_n_i,
    input  logic             sdin_i,
    input  logic [WIDTH-1:0] pin_i,
    output logic             sout_o,
    output logic             sout_n_o
);

    localparam int unsigned LAST = WIDTH - 1;

    logic             shift;
    logic             sbit;
    logic [WIDTH-1:0] stages;

    plso_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .ld_n_i  (ld_n_i),
        .sclk_i  (sclk_i),
        .sen_n_i (sen_n_i),
        .sdin_i  (sdin_i),
        .shift_o (shift),
        .sbit_o  (sbit)
    );

    plso_stages #(.WIDTH(WIDTH)) u_stg (
        .clk      (clk),
        .rst      (rst),
        .ld_n_i   (ld_n_i),
        .shift_i  (shift),
        .sbit_i   (sbit),
        .pin_i    (pin_i),
        .stages_o (stages)
    );

    assign sout_o   = stages[LAST];
    assign sout_n_o = ~stages[LAST];

    AST_LOAD_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
        !ld_n_i |=> sout_o == $past(pin_i[LAST])); // R3

endmodule

// File: tb/sim_plso_shift8.sv
module sim_plso_shift8;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_n = 1'b1;
    logic         cp = 1'b1;
    logic         ce_n = 1'b0;
    logic         ser = 1'b1;
    logic [W-1:0] par = '0;
    logic         q, qn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plso_shift8 #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .ld_n_i(ld_n), .sclk_i(cp), .sen_n_i(ce_n),
        .sdin_i(ser), .pin_i(par), .sout_o(q), .sout_n_o(qn)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_pos(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic check_outs(input logic exp, input string tag);
        check(q == exp, tag, q, exp);
        check(qn == ~q, "R6 complement", qn, ~q);
    endtask

    // one enabled shift; sdin held at s while the gated clock is low,
    // changed to s_rise in the cycle of the rise
    task automatic do_shift(input logic s, input logic s_rise, input logic exp, input string tag);
        @(negedge clk); cp = 1'b0; ce_n = 1'b0; ser = s;
        wait_pos(2);
        @(negedge clk); cp = 1'b1; ser = s_rise;
        wait_pos(2);
        @(negedge clk);
        check_outs(exp, tag);
    endtask

    task automatic load_word(input logic [W-1:0] v, input logic en_n);
        @(negedge clk); ld_n = 1'b0; par = v; cp = 1'b0; ce_n = en_n;
        @(posedge clk);
        @(negedge clk);
        check_outs(v[W-1], "R2 load");
        ld_n = 1'b1;
    endtask

    initial begin
        wait_pos(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check_outs(1'b0, "R1 reset state");
        // gated clock was high across reset: seven ones must not reach the end
        for (int j = 1; j <= 8; j++) begin
            do_shift(1'b1, 1'b1, (j == 8), "R1 no spurious shift");
        end

        // exhaustive: every word out MSB first, then the serial stream
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] w;
            w = v[W-1:0];
            load_word(w, 1'b0);
            for (int j = 1; j <= 15; j++) begin
                logic s, e;
                s = (j <= 8) ? ~w[j-1] : 1'b0;
                e = (j < 8) ? w[7-j] : ~w[j-8];
                do_shift(s, s, e, "R10 stream");
            end
        end

        // level load: pin_i[7] tracks at the output, other inputs ignored
        @(negedge clk); ld_n = 1'b0; par = '0;
        for (int t = 0; t < 6; t++) begin
            par[W-1] = t[0]; cp = t[1]; ce_n = t[2]; ser = ~t[0];
            @(posedge clk);
            @(negedge clk);
            check_outs(t[0], "R3 level load");
        end
        cp = 1'b0; ce_n = 1'b0; ld_n = 1'b1;

        // hold: enable high, shift clock toggles
        @(negedge clk); ld_n = 1'b0; par = 8'hA5; ce_n = 1'b1; cp = 1'b0;
        wait_pos(2);
        @(negedge clk); ld_n = 1'b1;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk); cp = ~cp; ser = ~ser;
            wait_pos(2);
            @(negedge clk);
            check_outs(1'b1, "R5 hold");
        end
        @(negedge clk); cp = 1'b0; ce_n = 1'b0;
        wait_pos(2);
        do_shift(1'b0, 1'b0, 1'b0, "R5 word kept bit6");
        do_shift(1'b0, 1'b0, 1'b1, "R5 word kept bit5");
        do_shift(1'b0, 1'b0, 1'b0, "R5 word kept bit4");

        // enable edges
        load_word(8'h40, 1'b0);
        @(negedge clk); ser = 1'b0;
        wait_pos(2);
        @(negedge clk); ce_n = 1'b1;
        wait_pos(2);
        @(negedge clk);
        check_outs(1'b1, "R7 enable rise shifts");
        cp = 1'b1;
        wait_pos(2);
        @(negedge clk); ce_n = 1'b0;
        wait_pos(3);
        @(negedge clk);
        check_outs(1'b1, "R7 enable fall no shift");
        cp = 1'b0;

        // serial bit is the value before the rise
        load_word(8'h00, 1'b0);
        do_shift(1'b1, 1'b0, 1'b0, "R8 capture");
        for (int j = 2; j <= 8; j++) begin
            do_shift(1'b0, 1'b0, (j == 8), "R8 old value captured");
        end

        // gated clock rises during load; release must not shift
        @(negedge clk); ld_n = 1'b0; par = 8'h80; cp = 1'b0; ce_n = 1'b0;
        wait_pos(2);
        @(negedge clk); cp = 1'b1;
        wait_pos(3);
        @(negedge clk); ld_n = 1'b1;
        wait_pos(4);
        @(negedge clk);
        check_outs(1'b1, "R9 no shift on release");
        do_shift(1'b0, 1'b0, 1'b0, "R9 fresh edge shifts");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_pos(200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule